// File: doc/BRIEF.md
# Addressable Output Latch with One-Hot Demultiplex

This block holds a bank of eight output bits that can be written one bit at a time. A three-bit address picks the bit, and a single data input gives the value. Two active-low controls, a clear input and a load input, decide together what the bank does on each clock edge. It can clear the whole bank, or drive a one-of-eight pattern in which only the addressed bit carries data. It can also keep every bit as it is, or overwrite just the addressed bit.

The model is synchronous. All controls, the address and the data are sampled on the rising clock edge. The outputs come from registers and change only at that edge. A separate synchronous active-high reset gives the bank a defined start state. Typical uses are scattered control flags that a narrow bus sets one by one, or a three-to-eight decoder with a registered output.

Top module: `addr_latch`

## Requirements
- R1: With `rst` high at a rising edge, every bit of `q` is 0 after that edge, whatever the other inputs are. `rst` wins over every mode.
- R2: Clear mode (`clear_n`=0, `load_n`=1) sets all bits of `q` to 0 at the edge, for any `addr` and `din`.
- R3: Demultiplex mode (`clear_n`=0, `load_n`=0) sets the addressed bit of `q` to `din` and every other bit to 0 at the edge.
- R4: In demultiplex mode with `din`=1, `q` after the edge has exactly one bit high, so the block acts as a three-to-eight decoder.
- R5: Hold mode (`clear_n`=1, `load_n`=1) leaves `q` unchanged at the edge, for any `addr` and `din`.
- R6: Write mode (`clear_n`=1, `load_n`=0) sets the addressed bit of `q` to `din`. The other seven bits keep their values.
- R7: The addressed bit index equals the unsigned value of `addr`, with `addr[0]` as the least significant bit. Value 0 selects `q[0]` and value 7 selects `q[7]`.
- R8: When `load_n` stays low for several edges on one address while `din` changes, the bit keeps the `din` sampled at the last edge with `load_n` low. After `load_n` returns high, it holds that value.
- R9: `q` changes only at a rising clock edge. It shows the inputs sampled at that edge one edge later, so a change of inputs between edges leaves `q` untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; clears `q` |
| clear_n | input | 1 | Active-low functional clear; combined with `load_n` to select the mode |
| load_n | input | 1 | Active-low load enable; combined with `clear_n` to select the mode |
| addr | input | 3 | Bit index into the output bank, `addr[0]` least significant |
| din | input | 1 | Data bit for the addressed output |
| q | output | 8 | Registered output bank |

## Verification
Two functions can meet in one cycle. The first is `rst` together with an active write or demultiplex mode: the bench raises `rst` while `load_n` is low on an address whose bit is already set, and expects an all-zero bank. The second is a clear or demultiplex edge that lands on a bank full of bits from earlier writes. Here the bench checks that the unaddressed bits are forced low in the same edge that loads the addressed bit. A behavioural model of the bank is compared after every edge, during directed sequences and during a long random run of modes, addresses and data.

// File: rtl/addr_latch_pkg.sv
`timescale 1ns/1ps
package addr_latch_pkg;

  // Operating mode, decoded from {clear_n, load_n}
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_CLEAR = 2'b01,
    MODE_WRITE = 2'b10,
    MODE_HOLD  = 2'b11
  } mode_t;

endpackage

// File: rtl/addr_latch_mode_dec.sv
`timescale 1ns/1ps
module addr_latch_mode_dec
  import addr_latch_pkg::*;
(
  input  logic  clear_n,
  input  logic  load_n,
  output mode_t mode
);

  always_comb begin
    unique case ({clear_n, load_n})
      2'b00:   mode = MODE_DEMUX;
      2'b01:   mode = MODE_CLEAR;
      2'b10:   mode = MODE_WRITE;
      default: mode = MODE_HOLD;
    endcase
  end

endmodule

// File: rtl/addr_latch_onehot.sv
`timescale 1ns/1ps
module addr_latch_onehot #(
  parameter int WIDTH = 8,
  localparam int AW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [AW-1:0]    addr,
  output logic [WIDTH-1:0] hot
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cmp
    assign hot[i] = (addr == AW'(i));
  end

endmodule

// File: rtl/addr_latch_bank.sv
`timescale 1ns/1ps
module addr_latch_bank
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_t            mode,
  input  logic [WIDTH-1:0] hot,
  input  logic             din,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic nxt;

    always_comb begin
      unique case (mode)
        MODE_CLEAR: nxt = 1'b0;
        MODE_DEMUX: nxt = hot[i] & din;
        MODE_WRITE: nxt = hot[i] ? din : q[i];
        default:    nxt = q[i];
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nxt;
    end
  end

endmodule

// File: rtl/addr_latch.sv
`timescale 1ns/1ps
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic [AW-1:0]    addr,
  input  logic             din,
  output logic [WIDTH-1:0] q
);

  mode_t            mode;
  logic [WIDTH-1:0] hot;

  addr_latch_mode_dec u_mode (
    .clear_n (clear_n),
    .load_n  (load_n),
    .mode    (mode)
  );

  addr_latch_onehot #(.WIDTH(WIDTH)) u_hot (
    .addr (addr),
    .hot  (hot)
  );

  addr_latch_bank #(.WIDTH(WIDTH)) u_bank (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .hot  (hot),
    .din  (din),
    .q    (q)
  );

endmodule

// File: rtl/addr_latch_chk.sv
`timescale 1ns/1ps
module addr_latch_chk #(
  parameter int WIDTH = 8,
  localparam int AW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             clear_n,
  input logic             load_n,
  input logic [AW-1:0]    addr,
  input logic             din,
  input logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] sel_mask;
  assign sel_mask = WIDTH'(1) << addr;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R2
  clear_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && load_n) |=> (q == '0));

  // R3
  demux_pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && !load_n) |=> (q == ($past(din) ? $past(sel_mask) : '0)));

  // R4
  decoder_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear_n && !load_n && din) |=> ($countones(q) == 1));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n) |=> $stable(q));

  // R6
  write_others_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !load_n) |=> (((q ^ $past(q)) & ~$past(sel_mask)) == '0));

  // R6
  write_target_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !load_n) |=>
      ((q & $past(sel_mask)) == ($past(din) ? $past(sel_mask) : '0)));

endmodule

bind addr_latch addr_latch_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/addr_latch_bench.sv
`timescale 1ns/1ps
module addr_latch_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear_n = 1'b1;
  logic       load_n = 1'b1;
  logic [2:0] addr = '0;
  logic       din = 1'b0;
  logic [7:0] q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] model = '0;

  always #2.5 clk = ~clk;

  addr_latch u_addr_latch (
    .clk(clk), .rst(rst), .clear_n(clear_n), .load_n(load_n),
    .addr(addr), .din(din), .q(q)
  );

  task automatic check(input string tag, input logic [7:0] exp);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s: q=%b expected=%b at %0t", tag, q, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, check no early change (R9), then the result.
  task automatic step(input logic r, input logic c, input logic l,
                      input logic [2:0] a, input logic d, input string tag);
    @(negedge clk);
    rst = r; clear_n = c; load_n = l; addr = a; din = d;
    #1;
    check("R9", model);
    @(posedge clk);
    if (r) model = '0;
    else begin
      case ({c, l})
        2'b01: model = '0;
        2'b00: begin model = '0; model[a] = d; end
        2'b10: model[a] = d;
        default: ;
      endcase
    end
    #1;
    check(tag, model);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    check("R1", 8'h00);
    step(1'b0, 1'b1, 1'b1, 3'd0, 1'b0, "R5");

    // R6 / R7 single-bit writes, index boundaries
    step(1'b0, 1'b1, 1'b0, 3'd0, 1'b1, "R7");
    check("R7", 8'b0000_0001);
    step(1'b0, 1'b1, 1'b0, 3'd7, 1'b1, "R7");
    check("R7", 8'b1000_0001);
    step(1'b0, 1'b1, 1'b0, 3'd3, 1'b1, "R6");
    check("R6", 8'b1000_1001);
    step(1'b0, 1'b1, 1'b0, 3'd0, 1'b0, "R6");
    check("R6", 8'b1000_1000);

    // R5 hold ignores address and data
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 3'(i), i[0], "R5");
    check("R5", 8'b1000_1000);

    // R8 last data while load low is kept
    step(1'b0, 1'b1, 1'b0, 3'd2, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b0, 3'd2, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b0, 3'd2, 1'b1, "R8");
    step(1'b0, 1'b1, 1'b1, 3'd2, 1'b0, "R8");
    check("R8", 8'b1000_1100);

    // R3 / R4 demultiplex over a populated bank
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 1'b0, 3'(i), 1'b1, "R4");
      check("R4", 8'(1) << i);
    end
    step(1'b0, 1'b1, 1'b0, 3'd6, 1'b1, "R6");
    step(1'b0, 1'b0, 1'b0, 3'd5, 1'b1, "R3");
    check("R3", 8'b0010_0000);
    step(1'b0, 1'b0, 1'b0, 3'd5, 1'b0, "R3");
    check("R3", 8'h00);

    // R2 clear from a full bank
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0, 3'(i), 1'b1, "R6");
    check("R6", 8'hFF);
    step(1'b0, 1'b0, 1'b1, 3'd4, 1'b1, "R2");
    check("R2", 8'h00);

    // R1 reset wins over a write in the same cycle
    step(1'b0, 1'b1, 1'b0, 3'd1, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b0, 3'd1, 1'b1, "R1");
    check("R1", 8'h00);
    step(1'b1, 1'b0, 1'b0, 3'd4, 1'b1, "R1");
    check("R1", 8'h00);

    // Random run against the model
    for (int n = 0; n < 3000; n++) begin
      int m;
      m = $urandom_range(0, 3);
      step(($urandom_range(0, 63) == 0), m[1], m[0],
           3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule